// File: doc/BRIEF.md
# Deferred Load Replay Unit

This unit parks loads that the memory-side dependence predictor has flagged as probably depending on an older store of the same block. A parked load does not use its cache result. It waits until every store with a smaller LSID in its block has reached the data tile. The unit then sends it back into the main load pipeline as if it were a brand-new load.

Store arrival is supplied as a per-frame "settled" bit vector, one bit per LSID. A bit means either that the store at that LSID has arrived or that no store uses it. A parked load becomes eligible once every bit below its own LSID is set in its frame's row; it never matches on address.

Replay runs in three steps. An entry is marked woken in cycle X. A round-robin selector moves one woken entry into a prepare register in cycle X+1, provided the LSQ resources are free. The load then appears on the replay output in cycle X+2 and stays there until the main pipeline takes it. Loads that sit between the same two stores may therefore replay in any order. A whole frame's parked loads can be discarded in one cycle. When every entry is in use, a stall goes back to the load pipeline.

Top module: `dlr_replay_unit`

## Requirements
- R1: After reset `replay_valid` and `park_full` are low, and nothing is replayed until a load has been inserted.
- R2: An inserted load takes the lowest-numbered free entry (entries are numbered 0 to 15). It is replayed with exactly the frame, LSID and address it was inserted with.
- R3: The settled vector holds one row of 32 bits per frame. Bit `f*32+k` set means LSID k of frame f is settled. An entry that holds LSID L of frame f is marked woken at a clock edge only if bits `f*32+0` to `f*32+L-1` are all set in the cycle before that edge. Bits at L and above have no effect, and LSID 0 needs no bits.
- R4: Wake is evaluated from the cycle after insertion. An entry marked woken at the edge that starts cycle X shows on the replay output in cycle X+2 when `lsq_busy` is low, the output is free and no other woken entry is chosen first.
- R5: Among woken entries the one chosen is the first found from the entry after the last one chosen, wrapping from 15 to 0. Loads may therefore leave in an order different from their LSIDs.
- R6: In a cycle with `lsq_busy` high no woken entry enters the prepare step. The entry stays woken and is picked later.
- R7: While `replay_valid` is high and `pipe_accept` is low, the replay frame, LSID and address hold unchanged. The load behind it is not lost.
- R8: A cycle with `flush_valid` high frees every parked or woken entry whose frame equals `flush_frame`, and none of them is ever replayed. A load inserted in that same cycle is kept. Loads already in the prepare or output step are not affected.
- R9: `park_full` is high exactly when all 16 entries are occupied. An insertion offered while it is high is discarded and never replayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Deferred load offered for parking |
| ins_frame | input | 3 | Frame of the offered load |
| ins_lsid | input | 5 | LSID of the offered load |
| ins_addr | input | 32 | Address of the offered load |
| stores_settled | input | 256 | Per-frame settled-LSID rows, bit f*32+k |
| flush_valid | input | 1 | Discard parked loads of one frame |
| flush_frame | input | 3 | Frame to discard |
| lsq_busy | input | 1 | LSQ resources unavailable for preparation this cycle |
| pipe_accept | input | 1 | Main pipeline takes the replayed load this cycle |
| replay_valid | output | 1 | A load is offered for re-injection |
| replay_frame | output | 3 | Frame of the replayed load |
| replay_lsid | output | 5 | LSID of the replayed load |
| replay_addr | output | 32 | Address of the replayed load |
| park_full | output | 1 | All entries occupied; stall new deferrals |

## Verification
A slot that loses its state or skips a wake shows up as a load missing from the replay stream, or as a load that appears earlier than the settled rows allow. The per-cycle reference comparison reports this in the first cycle the replay output differs, which is at most two cycles after the faulty wake. A round-robin pointer that is stuck or wrong changes which load leaves first among loads woken together, so the replayed LSID differs at once. A flush that does not take effect brings the discarded load back to the output within a few cycles of its row settling. A wrong occupancy count makes `park_full` differ in the cycle it is registered.

// File: rtl/dlr_pkg.sv
package dlr_pkg;
    // Occupancy of one parking slot
    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_PARKED = 2'd1,
        SLOT_READY  = 2'd2
    } slot_state_e;

    localparam int DEF_SLOTS   = 16;
    localparam int DEF_FRAME_W = 3;
    localparam int DEF_LSID_W  = 5;
    localparam int DEF_ADDR_W  = 32;
endpackage

// File: rtl/dlr_slot_table.sv
module dlr_slot_table
    import dlr_pkg::*;
#(
    parameter int SLOTS   = DEF_SLOTS,
    parameter int FRAME_W = DEF_FRAME_W,
    parameter int LSID_W  = DEF_LSID_W,
    parameter int ADDR_W  = DEF_ADDR_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ins_valid_i,
    input  logic [FRAME_W-1:0]                ins_frame_i,
    input  logic [LSID_W-1:0]                 ins_lsid_i,
    input  logic [ADDR_W-1:0]                 ins_addr_i,
    input  logic [(1<<FRAME_W)*(1<<LSID_W)-1:0] settled_i,
    input  logic                              flush_valid_i,
    input  logic [FRAME_W-1:0]                flush_frame_i,
    input  logic                              take_i,
    input  logic [$clog2(SLOTS)-1:0]          take_idx_i,
    output logic [SLOTS-1:0]                  ready_o,
    output logic                              full_o,
    output logic [FRAME_W-1:0]                sel_frame_o,
    output logic [LSID_W-1:0]                 sel_lsid_o,
    output logic [ADDR_W-1:0]                 sel_addr_o
);
    localparam int IDX_W = $clog2(SLOTS);
    localparam int LSIDS = 1 << LSID_W;

    typedef struct packed {
        slot_state_e          st;
        logic [FRAME_W-1:0]   fr;
        logic [LSID_W-1:0]    ls;
        logic [ADDR_W-1:0]    ad;
    } slot_t;

    typedef struct packed {
        slot_t [SLOTS-1:0] slot;
    } table_t;

    table_t            tbl_d, tbl_q;
    logic [SLOTS-1:0]  wake_ok;
    logic [SLOTS-1:0]  flush_hit;
    logic [SLOTS-1:0]  live;
    logic              have_free;
    logic [IDX_W-1:0]  free_idx;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [LSIDS-1:0] row;
        logic [LSIDS-1:0] below;
        assign row   = settled_i[{tbl_q.slot[g].fr, {LSID_W{1'b0}}} +: LSIDS];
        assign below = (LSIDS'(1) << tbl_q.slot[g].ls) - LSIDS'(1);
        assign wake_ok[g]   = ((row & below) == below);
        assign live[g]      = (tbl_q.slot[g].st != SLOT_FREE);
        assign flush_hit[g] = flush_valid_i && live[g] &&
                              (tbl_q.slot[g].fr == flush_frame_i);
        assign ready_o[g]   = (tbl_q.slot[g].st == SLOT_READY) && !flush_hit[g];

        // R3
        wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tbl_q.slot[g].st == SLOT_PARKED) && !wake_ok[g]
            |=> (tbl_q.slot[g].st != SLOT_READY));

        // R8
        flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush_valid_i && !(ins_valid_i && (ins_frame_i == flush_frame_i))
            |=> !(live[g] && (tbl_q.slot[g].fr == $past(flush_frame_i))));
    end

    always_comb begin
        tbl_d     = tbl_q;
        have_free = 1'b0;
        free_idx  = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (tbl_q.slot[k].st == SLOT_FREE) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(k);
            end
        end
        for (int k = 0; k < SLOTS; k++) begin
            if (flush_hit[k]) begin
                tbl_d.slot[k].st = SLOT_FREE;
            end else if (take_i && (take_idx_i == IDX_W'(k))) begin
                tbl_d.slot[k].st = SLOT_FREE;
            end else if ((tbl_q.slot[k].st == SLOT_PARKED) && wake_ok[k]) begin
                tbl_d.slot[k].st = SLOT_READY;
            end
        end
        if (ins_valid_i && have_free) begin
            tbl_d.slot[free_idx].st = SLOT_PARKED;
            tbl_d.slot[free_idx].fr = ins_frame_i;
            tbl_d.slot[free_idx].ls = ins_lsid_i;
            tbl_d.slot[free_idx].ad = ins_addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign full_o      = !have_free;
    assign sel_frame_o = tbl_q.slot[take_idx_i].fr;
    assign sel_lsid_o  = tbl_q.slot[take_idx_i].ls;
    assign sel_addr_o  = tbl_q.slot[take_idx_i].ad;

    // R2
    occupancy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid_i && have_free && !flush_valid_i && !take_i
        |=> ($countones(live) == $past($countones(live)) + 1));

    // R5
    take_is_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (tbl_q.slot[take_idx_i].st == SLOT_READY));
endmodule

// File: rtl/dlr_rr_pick.sv
module dlr_rr_pick #(
    parameter int SLOTS = 16   // power of two
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SLOTS-1:0]         req_i,
    input  logic                     en_i,
    output logic                     gvalid_o,
    output logic [$clog2(SLOTS)-1:0] gidx_o
);
    localparam int IDX_W = $clog2(SLOTS);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } rr_t;

    rr_t              rr_d, rr_q;
    logic             found;
    logic [IDX_W-1:0] cand;
    logic [IDX_W-1:0] pick;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        cand  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            cand = rr_q.ptr + IDX_W'(i);
            if (!found && req_i[cand]) begin
                found = 1'b1;
                pick  = cand;
            end
        end
        rr_d = rr_q;
        if (found && en_i) begin
            rr_d.ptr = pick + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else begin
            rr_q <= rr_d;
        end
    end

    assign gvalid_o = found && en_i;
    assign gidx_o   = pick;

    // R5
    grant_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gvalid_o |-> req_i[gidx_o]);

    // R5
    grant_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !gvalid_o);
endmodule

// File: rtl/dlr_replay_pipe.sv
module dlr_replay_pipe #(
    parameter int FRAME_W = 3,
    parameter int LSID_W  = 5,
    parameter int ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] load_frame_i,
    input  logic [LSID_W-1:0]  load_lsid_i,
    input  logic [ADDR_W-1:0]  load_addr_i,
    input  logic               accept_i,
    output logic               prep_ready_o,
    output logic               prep_valid_o,
    output logic               out_valid_o,
    output logic [FRAME_W-1:0] out_frame_o,
    output logic [LSID_W-1:0]  out_lsid_o,
    output logic [ADDR_W-1:0]  out_addr_o
);
    typedef struct packed {
        logic               pv;
        logic [FRAME_W-1:0] pf;
        logic [LSID_W-1:0]  pl;
        logic [ADDR_W-1:0]  pa;
        logic               ov;
        logic [FRAME_W-1:0] of;
        logic [LSID_W-1:0]  ol;
        logic [ADDR_W-1:0]  oa;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  out_ready;
    logic  prep_ready;

    always_comb begin
        out_ready  = !pipe_q.ov || accept_i;
        prep_ready = !pipe_q.pv || out_ready;
        pipe_d     = pipe_q;
        if (out_ready) begin
            pipe_d.ov = pipe_q.pv;
            pipe_d.of = pipe_q.pf;
            pipe_d.ol = pipe_q.pl;
            pipe_d.oa = pipe_q.pa;
        end
        if (prep_ready) begin
            pipe_d.pv = load_i;
            if (load_i) begin
                pipe_d.pf = load_frame_i;
                pipe_d.pl = load_lsid_i;
                pipe_d.pa = load_addr_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign prep_ready_o = prep_ready;
    assign prep_valid_o = pipe_q.pv;
    assign out_valid_o  = pipe_q.ov;
    assign out_frame_o  = pipe_q.of;
    assign out_lsid_o   = pipe_q.ol;
    assign out_addr_o   = pipe_q.oa;

    // R7
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.ov && !accept_i
        |=> pipe_q.ov && $stable(pipe_q.of) && $stable(pipe_q.ol) && $stable(pipe_q.oa));

    // R4
    out_from_prep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pipe_q.ov) |-> $past(pipe_q.pv));
endmodule

// File: rtl/dlr_replay_unit.sv
module dlr_replay_unit
    import dlr_pkg::*;
#(
    parameter int SLOTS   = DEF_SLOTS,
    parameter int FRAME_W = DEF_FRAME_W,
    parameter int LSID_W  = DEF_LSID_W,
    parameter int ADDR_W  = DEF_ADDR_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  ins_valid,
    input  logic [FRAME_W-1:0]                    ins_frame,
    input  logic [LSID_W-1:0]                     ins_lsid,
    input  logic [ADDR_W-1:0]                     ins_addr,
    input  logic [(1<<FRAME_W)*(1<<LSID_W)-1:0]   stores_settled,
    input  logic                                  flush_valid,
    input  logic [FRAME_W-1:0]                    flush_frame,
    input  logic                                  lsq_busy,
    input  logic                                  pipe_accept,
    output logic                                  replay_valid,
    output logic [FRAME_W-1:0]                    replay_frame,
    output logic [LSID_W-1:0]                     replay_lsid,
    output logic [ADDR_W-1:0]                     replay_addr,
    output logic                                  park_full
);
    localparam int IDX_W = $clog2(SLOTS);

    logic [SLOTS-1:0]   ready_vec;
    logic               prep_ready;
    logic               prep_valid;
    logic               take_en;
    logic               take;
    logic [IDX_W-1:0]   take_idx;
    logic [FRAME_W-1:0] sel_frame;
    logic [LSID_W-1:0]  sel_lsid;
    logic [ADDR_W-1:0]  sel_addr;

    assign take_en = prep_ready && !lsq_busy;

    dlr_slot_table #(
        .SLOTS(SLOTS), .FRAME_W(FRAME_W), .LSID_W(LSID_W), .ADDR_W(ADDR_W)
    ) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_valid_i  (ins_valid),
        .ins_frame_i  (ins_frame),
        .ins_lsid_i   (ins_lsid),
        .ins_addr_i   (ins_addr),
        .settled_i    (stores_settled),
        .flush_valid_i(flush_valid),
        .flush_frame_i(flush_frame),
        .take_i       (take),
        .take_idx_i   (take_idx),
        .ready_o      (ready_vec),
        .full_o       (park_full),
        .sel_frame_o  (sel_frame),
        .sel_lsid_o   (sel_lsid),
        .sel_addr_o   (sel_addr)
    );

    dlr_rr_pick #(
        .SLOTS(SLOTS)
    ) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (ready_vec),
        .en_i    (take_en),
        .gvalid_o(take),
        .gidx_o  (take_idx)
    );

    dlr_replay_pipe #(
        .FRAME_W(FRAME_W), .LSID_W(LSID_W), .ADDR_W(ADDR_W)
    ) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (take),
        .load_frame_i(sel_frame),
        .load_lsid_i (sel_lsid),
        .load_addr_i (sel_addr),
        .accept_i    (pipe_accept),
        .prep_ready_o(prep_ready),
        .prep_valid_o(prep_valid),
        .out_valid_o (replay_valid),
        .out_frame_o (replay_frame),
        .out_lsid_o  (replay_lsid),
        .out_addr_o  (replay_addr)
    );

    // R6
    busy_blocks_prep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lsq_busy && !prep_valid |=> !prep_valid);

    // R9
    full_ignores_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        park_full && !flush_valid && !take |=> park_full);
endmodule

// File: tb/dlr_replay_unit_bench.sv
`timescale 1ns/1ps
module dlr_replay_unit_bench;
    localparam int SLOTS = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ins_valid = 1'b0;
    logic [2:0]   ins_frame = '0;
    logic [4:0]   ins_lsid = '0;
    logic [31:0]  ins_addr = '0;
    logic [255:0] settled = '0;
    logic         flush_valid = 1'b0;
    logic [2:0]   flush_frame = '0;
    logic         lsq_busy = 1'b0;
    logic         pipe_accept = 1'b1;
    logic         replay_valid;
    logic [2:0]   replay_frame;
    logic [4:0]   replay_lsid;
    logic [31:0]  replay_addr;
    logic         park_full;

    always #2 clk = ~clk;   // 250 MHz

    dlr_replay_unit u_dlr_replay_unit (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_frame(ins_frame), .ins_lsid(ins_lsid), .ins_addr(ins_addr),
        .stores_settled(settled), .flush_valid(flush_valid), .flush_frame(flush_frame),
        .lsq_busy(lsq_busy), .pipe_accept(pipe_accept),
        .replay_valid(replay_valid), .replay_frame(replay_frame), .replay_lsid(replay_lsid),
        .replay_addr(replay_addr), .park_full(park_full)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int          m_st [SLOTS];   // 0 empty, 1 waiting, 2 woken
    int          m_fr [SLOTS];
    int          m_ls [SLOTS];
    longint      m_ad [SLOTS];
    int          m_rr;
    bit          m_pv, m_ov;
    int          m_pf, m_pl, m_of, m_ol;
    longint      m_pa, m_oa;
    longint      accepted[$];
    bit          out_rdy, prep_rdy, take;
    int          pick, fslot, cidx;

    function automatic bit m_cond(int f, int l);
        for (int j = 0; j < l; j++) if (!settled[f*32 + j]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int seen(longint a);
        int c = 0;
        foreach (accepted[i]) if (accepted[i] == a) c++;
        return c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SLOTS; k++) m_st[k] = 0;
            m_rr = 0; m_pv = 0; m_ov = 0;
        end else begin
            if (m_ov && pipe_accept) accepted.push_back(m_oa);
            out_rdy  = !m_ov || pipe_accept;
            prep_rdy = !m_pv || out_rdy;
            take     = prep_rdy && !lsq_busy;
            pick = -1;
            for (int i = 0; i < SLOTS; i++) begin
                cidx = (m_rr + i) % SLOTS;
                if (pick < 0 && m_st[cidx] == 2 && !(flush_valid && m_fr[cidx] == int'(flush_frame)))
                    pick = cidx;
            end
            fslot = -1;
            for (int k = SLOTS - 1; k >= 0; k--) if (m_st[k] == 0) fslot = k;
            if (out_rdy) begin
                m_ov = m_pv; m_of = m_pf; m_ol = m_pl; m_oa = m_pa;
            end
            if (prep_rdy) begin
                m_pv = take && (pick >= 0);
                if (m_pv) begin
                    m_pf = m_fr[pick]; m_pl = m_ls[pick]; m_pa = m_ad[pick];
                end
            end
            for (int k = 0; k < SLOTS; k++) begin
                if (m_st[k] != 0 && flush_valid && m_fr[k] == int'(flush_frame)) m_st[k] = 0;
                else if (take && k == pick) m_st[k] = 0;
                else if (m_st[k] == 1 && m_cond(m_fr[k], m_ls[k])) m_st[k] = 2;
            end
            if (ins_valid && fslot >= 0) begin
                m_st[fslot] = 1; m_fr[fslot] = int'(ins_frame);
                m_ls[fslot] = int'(ins_lsid); m_ad[fslot] = longint'(ins_addr);
            end
            if (take && pick >= 0) m_rr = (pick + 1) % SLOTS;
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4", "replay_valid vs model", longint'(replay_valid), longint'(m_ov));
            if (m_ov) begin
                chk("R5", "replay_lsid vs model", longint'(replay_lsid), longint'(m_ol));
                chk("R2", "replay_frame vs model", longint'(replay_frame), longint'(m_of));
                chk("R2", "replay_addr vs model", longint'(replay_addr), m_oa);
            end
            chk("R9", "park_full vs model", longint'(park_full), longint'(fslot_free_none()));
        end
    end

    function automatic bit fslot_free_none();
        for (int k = 0; k < SLOTS; k++) if (m_st[k] == 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input int f, input int l, input longint a);
        ins_valid = 1'b1; ins_frame = 3'(f); ins_lsid = 5'(l); ins_addr = 32'(a);
        step();
        ins_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1", "replay_valid after reset", longint'(replay_valid), 0);
        chk("R1", "park_full after reset", longint'(park_full), 0);
        step(3);
        chk("R1", "no replay without insert", longint'(replay_valid), 0);

        // R3 / R4: wake only when all lower LSIDs settled, then two cycles to output
        put(1, 5, 'h100);
        step(4);
        chk("R3", "waits with row empty", longint'(replay_valid), 0);
        settled[32 +: 4] = 4'hF;
        step(4);
        chk("R3", "waits with LSID 4 unsettled", longint'(replay_valid), 0);
        settled[32 + 4] = 1'b1;
        step(2);
        chk("R4", "not yet at X+1", longint'(replay_valid), 0);
        step();
        chk("R4", "valid at X+2", longint'(replay_valid), 1);
        chk("R2", "lsid carried", longint'(replay_lsid), 5);
        chk("R2", "frame carried", longint'(replay_frame), 1);
        chk("R2", "addr carried", longint'(replay_addr), 'h100);
        step();
        chk("R4", "cleared after accept", longint'(replay_valid), 0);

        // R5: round robin from entry 1 gives LSIDs 6, 4, 9
        settled = '0;
        put(0, 9, 'h209);
        put(0, 6, 'h206);
        put(0, 4, 'h204);
        settled[0 +: 32] = '1;
        step(3);
        chk("R5", "first pick", longint'(replay_lsid), 6);
        step();
        chk("R5", "second pick", longint'(replay_lsid), 4);
        step();
        chk("R5", "third pick wraps", longint'(replay_lsid), 9);
        step(2);

        // R6: busy LSQ holds the woken load
        settled = '0;
        lsq_busy = 1'b1;
        put(2, 0, 'h300);
        step(6);
        chk("R6", "no replay while busy", longint'(replay_valid), 0);
        lsq_busy = 1'b0;
        step();
        chk("R6", "prepare step only", longint'(replay_valid), 0);
        step();
        chk("R6", "replay after busy drops", longint'(replay_valid), 1);
        chk("R6", "replayed frame", longint'(replay_frame), 2);
        step(2);

        // R7: back-pressure holds output
        pipe_accept = 1'b0;
        settled[3*32 +: 32] = '1;
        put(3, 1, 'h401);
        put(3, 2, 'h402);
        step(8);
        chk("R7", "held valid", longint'(replay_valid), 1);
        chk("R7", "held lsid", longint'(replay_lsid), 1);
        step(3);
        chk("R7", "still held lsid", longint'(replay_lsid), 1);
        chk("R7", "still held addr", longint'(replay_addr), 'h401);
        pipe_accept = 1'b1;
        step();
        chk("R7", "next load follows", longint'(replay_lsid), 2);
        chk("R7", "next load valid", longint'(replay_valid), 1);
        step();
        chk("R7", "drained", longint'(replay_valid), 0);

        // R8: flush frame 4 with a same-cycle insert of frame 4
        settled = '0;
        put(4, 3, 'h503);
        put(5, 3, 'h513);
        flush_valid = 1'b1; flush_frame = 3'd4;
        put(4, 7, 'h507);
        flush_valid = 1'b0;
        settled = '1;
        step(12);
        chk("R8", "flushed load never replays", seen('h503), 0);
        chk("R8", "same-cycle insert kept", seen('h507), 1);
        chk("R8", "other frame unaffected", seen('h513), 1);

        // R9: fill all entries, offer one more
        settled = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (k == SLOTS - 1) chk("R9", "not full at 15", longint'(park_full), 0);
            put(6, k + 1, 'h600 + k);
        end
        chk("R9", "full at 16", longint'(park_full), 1);
        put(6, 0, 'hDEAD);
        settled = '1;
        step(40);
        chk("R9", "insert while full discarded", seen('hDEAD), 0);
        chk("R9", "all parked loads replayed", seen('h600) + seen('h60F), 2);
        chk("R9", "full released", longint'(park_full), 0);

        // random traffic against the reference
        settled = '0;
        for (int c = 0; c < 3000; c++) begin
            ins_valid   = !park_full && ($urandom % 3 == 0);
            ins_frame   = 3'($urandom);
            ins_lsid    = 5'($urandom);
            ins_addr    = $urandom;
            flush_valid = ($urandom % 25 == 0);
            flush_frame = 3'($urandom);
            lsq_busy    = ($urandom % 4 == 0);
            pipe_accept = ($urandom % 4 != 0);
            if (c % 8 == 0)
                for (int f = 0; f < 8; f++) settled[f*32 +: 32] = $urandom | ($urandom & settled[f*32 +: 32]);
            step();
        end
        ins_valid = 1'b0; flush_valid = 1'b0; lsq_busy = 1'b0; pipe_accept = 1'b1;
        step(4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule